// File: doc/BRIEF.md
# Monochrome LCD Scan-Out Controller

This block refreshes a 240x160 passive monochrome LCD panel with one bit per pixel. It reads packed pixel bytes from an external frame store through a synchronous-read port. It puts four horizontally adjacent pixels on a 4-bit data bus in every clock. It also generates the line-latch pulse (hsync), the frame-start pulse (vsync) and the frame-polarity signal (fr). The block clock is forwarded unchanged to the panel as its continuous pixel clock, so one clock carries one 4-pixel group.

The frame store holds two full frames. One frame is scanned out while the host draws into the other through its own write port. The host asks for a swap by pulsing a request. The block latches the request and exchanges the two buffers only at the end of the last line of a frame, so a frame never tears. A one-clock done strobe then tells the host that the old display buffer is free for drawing. A frame buffer holds one byte per pixel group (9600 bytes). Only the low nibble of each byte is pixel data.

Top module: `lcd_scan`

## Requirements
- R1: While rst_ni is low and until the first scanned group arrives, lcd_data_o, lcd_hs_o, lcd_vs_o, lcd_fr_o, swap_done_o and disp_buf_o are 0.
- R2: Every line lasts 61 clocks with no gaps between lines or frames: 60 data clocks, then one hsync clock in which lcd_data_o is 0.
- R3: In data clock g (0..59) of line n, lcd_data_o equals bits [3:0] of the byte at buffer offset n*60+g. Bit 3 is the leftmost pixel of the group, and bits [7:4] of the byte are ignored.
- R4: lcd_hs_o is high for exactly one clock, directly after the 60th data clock of every line.
- R5: A frame has 160 lines. lcd_vs_o is high for all 61 clocks of line 0 and low in every other line.
- R6: lcd_fr_o toggles in the clock where lcd_vs_o rises and holds its value otherwise, so the first frame after reset has lcd_fr_o = 1.
- R7: rd_en_o is high in the 60 address clocks of each line. rd_addr_o = {display buffer bit, 14-bit offset n*60+g}, so buffer 1 starts at address 16384. Read data is taken one clock after the address, and the bus shows it one clock later again.
- R8: A swap_req_i pulse is held pending until the last hsync clock of a frame. At that point disp_buf_o flips and swap_done_o pulses for one clock, and the first line of the next frame is read from the new buffer. Several requests within one frame cause a single swap, and a frame without a request causes none.
- R9: draw_buf_o is always the inverse of disp_buf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, also forwarded to the panel |
| rst_ni | input | 1 | Active-low asynchronous reset |
| swap_req_i | input | 1 | Host request to exchange buffers |
| rd_en_o | output | 1 | Frame store read enable |
| rd_addr_o | output | 15 | Frame store read address {buffer, offset} |
| rd_data_i | input | 8 | Frame store read data, one clock latency |
| lcd_data_o | output | 4 | Four-pixel data bus, bit 3 leftmost |
| lcd_hs_o | output | 1 | Line latch pulse |
| lcd_vs_o | output | 1 | Frame start, high during line 0 |
| lcd_fr_o | output | 1 | Frame polarity |
| disp_buf_o | output | 1 | Buffer currently being scanned |
| draw_buf_o | output | 1 | Buffer free for host drawing |
| swap_done_o | output | 1 | One-clock strobe after a buffer swap |

## Verification
The assertions assume that the frame store returns the byte for the previous clock's address and that swap_req_i is a clean synchronous level. Under those assumptions every hsync is a lone clock with a blank bus, polarity moves only on a vsync rise, and the buffer bit changes only with a done strobe that is followed by the hsync ending the frame. The bench models the store as an address hash, so no memory array is needed. It pulses swap requests well inside a frame and never on a boundary clock. Over five full frames it checks every output on every clock, including a frame with no request, a frame with two requests, and a swap back to buffer 0.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  parameter int unsigned H_PIX   = 240;
  parameter int unsigned V_LINES = 160;
  parameter int unsigned BUS_W   = 4;
  parameter int unsigned BYTE_W  = 8;

  localparam int unsigned GROUPS      = H_PIX / BUS_W;
  localparam int unsigned FRAME_BYTES = GROUPS * V_LINES;
  localparam int unsigned OFF_W       = $clog2(FRAME_BYTES);
  localparam int unsigned ADDR_W      = OFF_W + 1;
  localparam int unsigned COL_W       = $clog2(GROUPS + 1);
  localparam int unsigned LINE_W      = $clog2(V_LINES);

  localparam logic [COL_W-1:0]  COL_HS    = COL_W'(GROUPS);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(V_LINES - 1);

  typedef struct packed {
    logic              vld;
    logic [COL_W-1:0]  col;
    logic [LINE_W-1:0] line;
  } pos_t;
endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_req_i,
  output pos_t              pos_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              disp_buf_o,
  output logic              swap_done_o
);
  logic [COL_W-1:0]  col_q;
  logic [LINE_W-1:0] line_q;
  logic [OFF_W-1:0]  off_q;
  logic              pend_q, disp_q, done_q;
  logic              in_data, frame_end, want_swap;

  assign in_data   = (col_q != COL_HS);
  assign frame_end = !in_data && (line_q == LINE_LAST);
  assign want_swap = pend_q || swap_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      line_q <= '0;
      off_q  <= '0;
    end else if (in_data) begin
      col_q <= col_q + 1'b1;
      off_q <= off_q + 1'b1;
    end else begin
      col_q  <= '0;
      line_q <= frame_end ? '0 : line_q + 1'b1;
      if (frame_end) off_q <= '0;
    end
  end

  // request held until the frame boundary, then consumed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      disp_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= want_swap && !frame_end;
      done_q <= frame_end && want_swap;
      if (frame_end && want_swap) disp_q <= ~disp_q;
    end
  end

  assign pos_o       = '{vld: 1'b1, col: col_q, line: line_q};
  assign rd_en_o     = in_data;
  assign rd_addr_o   = {disp_q, off_q};
  assign disp_buf_o  = disp_q;
  assign swap_done_o = done_q;
endmodule

// File: rtl/lcd_scan_out.sv
module lcd_scan_out
  import lcd_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pos_t              pos_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BUS_W-1:0]  lcd_data_o,
  output logic              lcd_hs_o,
  output logic              lcd_vs_o,
  output logic              lcd_fr_o
);
  pos_t p1_q;
  logic p1_data, p1_start;

  assign p1_data  = p1_q.vld && (p1_q.col != COL_HS);
  assign p1_start = p1_q.vld && (p1_q.col == '0) && (p1_q.line == '0);

  // stage 1 aligns position with the store's read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p1_q <= '0;
    else         p1_q <= pos_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcd_data_o <= '0;
      lcd_hs_o   <= 1'b0;
      lcd_vs_o   <= 1'b0;
      lcd_fr_o   <= 1'b0;
    end else begin
      lcd_data_o <= p1_data ? rd_data_i[BUS_W-1:0] : '0;
      lcd_hs_o   <= p1_q.vld && (p1_q.col == COL_HS);
      lcd_vs_o   <= p1_q.vld && (p1_q.line == '0);
      if (p1_start) lcd_fr_o <= ~lcd_fr_o;
    end
  end
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
  import lcd_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_req_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BUS_W-1:0]  lcd_data_o,
  output logic              lcd_hs_o,
  output logic              lcd_vs_o,
  output logic              lcd_fr_o,
  output logic              disp_buf_o,
  output logic              draw_buf_o,
  output logic              swap_done_o
);
  pos_t pos;

  lcd_scan_timing u_timing (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .swap_req_i  (swap_req_i),
    .pos_o       (pos),
    .rd_en_o     (rd_en_o),
    .rd_addr_o   (rd_addr_o),
    .disp_buf_o  (disp_buf_o),
    .swap_done_o (swap_done_o)
  );

  lcd_scan_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pos_i      (pos),
    .rd_data_i  (rd_data_i),
    .lcd_data_o (lcd_data_o),
    .lcd_hs_o   (lcd_hs_o),
    .lcd_vs_o   (lcd_vs_o),
    .lcd_fr_o   (lcd_fr_o)
  );

  assign draw_buf_o = ~disp_buf_o;
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk
  import lcd_scan_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [BUS_W-1:0] lcd_data_o,
  input logic             lcd_hs_o,
  input logic             lcd_vs_o,
  input logic             lcd_fr_o,
  input logic             disp_buf_o,
  input logic             draw_buf_o,
  input logic             swap_done_o
);
  AST_HS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_hs_o |=> !lcd_hs_o);  // R4
  AST_HS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_hs_o |-> (lcd_data_o == '0));  // R2
  AST_FR_ON_VS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_vs_o) |-> (lcd_fr_o != $past(lcd_fr_o)));  // R6
  AST_FR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(lcd_vs_o) |-> $stable(lcd_fr_o));  // R6
  AST_SWAP_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_done_o |=> lcd_hs_o);  // R8
  AST_BUF_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(disp_buf_o) |-> swap_done_o);  // R8
  AST_DRAW_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    draw_buf_o != disp_buf_o);  // R9
endmodule

bind lcd_scan lcd_scan_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lcd_data_o  (lcd_data_o),
  .lcd_hs_o    (lcd_hs_o),
  .lcd_vs_o    (lcd_vs_o),
  .lcd_fr_o    (lcd_fr_o),
  .disp_buf_o  (disp_buf_o),
  .draw_buf_o  (draw_buf_o),
  .swap_done_o (swap_done_o)
);

// File: tb/lcd_scan_bench.sv
`timescale 1ns/1ps
module lcd_scan_bench;
  localparam int LINE_CLK = 61;
  localparam int FRAME_CLK = LINE_CLK * 160;
  localparam int LAST_E = 5 * FRAME_CLK + 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        swap_req_i = 1'b0;
  logic        rd_en_o;
  logic [14:0] rd_addr_o;
  logic [7:0]  rd_data_i = '0;
  logic [3:0]  lcd_data_o;
  logic        lcd_hs_o, lcd_vs_o, lcd_fr_o;
  logic        disp_buf_o, draw_buf_o, swap_done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lcd_scan u_lcd_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .swap_req_i(swap_req_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .lcd_data_o(lcd_data_o), .lcd_hs_o(lcd_hs_o), .lcd_vs_o(lcd_vs_o),
    .lcd_fr_o(lcd_fr_o), .disp_buf_o(disp_buf_o), .draw_buf_o(draw_buf_o),
    .swap_done_o(swap_done_o)
  );

  // upper nibble is deliberately noisy to show it is ignored (R3)
  function automatic logic [7:0] pat(input logic [14:0] a);
    return {~a[7:4], a[3:0] ^ a[7:4] ^ a[11:8] ^ {a[14], a[13:12], a[14]}};
  endfunction

  // requests in frame 1 (two) and frame 3 (one)
  function automatic logic exp_buf(input int f);
    return (f == 2 || f == 3);
  endfunction

  always @(posedge clk_i)
    if (rd_en_o) rd_data_i <= pat(rd_addr_o);

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20.0 * (LAST_E + 1000));
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "data", 32'(lcd_data_o), 0);
    chk("R1", "hs/vs/fr", {29'd0, lcd_hs_o, lcd_vs_o, lcd_fr_o}, 0);
    chk("R1", "disp/done", {30'd0, disp_buf_o, swap_done_o}, 0);
    chk("R9", "draw", 32'(draw_buf_o), 1);
    rst_ni = 1'b1;
    for (int e = 1; e <= LAST_E; e++) begin
      @(negedge clk_i);
      begin
        int k, f0, c0, l0, j, f, c, l, m;
        logic [14:0] a;
        logic [3:0] d;
        logic sd;
        k  = e;
        f0 = k / FRAME_CLK;
        c0 = (k % FRAME_CLK) % LINE_CLK;
        l0 = (k % FRAME_CLK) / LINE_CLK;
        chk("R7", "rd_en", 32'(rd_en_o), 32'(c0 < 60));
        if (c0 < 60)
          chk("R7", "rd_addr", 32'(rd_addr_o), 32'({exp_buf(f0), 14'(l0 * 60 + c0)}));
        chk("R8", "disp_buf", 32'(disp_buf_o), 32'(exp_buf(f0)));
        chk("R9", "draw_buf", 32'(draw_buf_o), 32'(!exp_buf(f0)));
        m  = e - 1;
        sd = (m % FRAME_CLK == FRAME_CLK - 1) && (m / FRAME_CLK == 1 || m / FRAME_CLK == 3);
        chk("R8", "swap_done", 32'(swap_done_o), 32'(sd));
        j = e - 2;
        if (j < 0) begin
          chk("R1", "early outputs", {25'd0, lcd_data_o, lcd_hs_o, lcd_vs_o, lcd_fr_o}, 0);
        end else begin
          f = j / FRAME_CLK;
          c = (j % FRAME_CLK) % LINE_CLK;
          l = (j % FRAME_CLK) / LINE_CLK;
          a = {exp_buf(f), 14'(l * 60 + c)};
          d = (c < 60) ? pat(a)[3:0] : 4'd0;
          if (c < 60) chk("R3", "data", 32'(lcd_data_o), 32'(d));
          else        chk("R2", "blank data", 32'(lcd_data_o), 0);
          chk("R4", "hs", 32'(lcd_hs_o), 32'(c == 60));
          chk("R5", "vs", 32'(lcd_vs_o), 32'(l == 0));
          chk("R6", "fr", 32'(lcd_fr_o), 32'(f % 2 == 0));
        end
      end
      swap_req_i = (e == FRAME_CLK + 3000) || (e == FRAME_CLK + 6000) ||
                   (e == 3 * FRAME_CLK + 100);
    end
    done = 1;
    summary();
  end
endmodule